// File: doc/BRIEF.md
# Single-Cycle Stack Processor Core

This block is a 32-bit processor core that completes one 16-bit instruction in every clock cycle. It has no register file. Every operand comes from a 16-deep last-in-first-out stack of 32-bit words, and every result goes back onto it. Memory addresses, branch targets and saved program counters are also taken from the top of that stack.

The core drives a byte-addressed instruction fetch port and a data memory port. Both memories sit outside the block and must answer combinationally within the same cycle. An instruction word carries a group code in bits [15:13], a sub-code in bits [12:10] and a 10-bit immediate in bits [9:0]. The immediate is sign-extended to 32 bits.

In the text below, "top" means the newest stack entry and "second" means the entry just beneath it. The program counter moves through a small set of named transitions: sequential (PC+2), conditional taken (PC := top), and jump-from-stack (PC := top). Synchronous reset returns the core to its only start state: PC 0 and stack empty.

Top module: `stk_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC (`imem_addr`) becomes 0 and the stack becomes empty (`stack_empty`=1, `stack_full`=0).
- R2: After any instruction whose group is 000, 001, 010, 011, 100 or 110, the PC advances by 2.
- R3: Group 000 pops two entries and pushes one result. Sub-codes: 000 second+top, 001 second−top, 010 −top, 011 low 32 bits of second×top, 100 AND, 101 OR, 110 XOR, 111 ~top.
- R4: Group 001 pops one entry and pushes the result of the same eight sub-coded operations. The first operand is the top entry and the second is the sign-extended immediate. Negate and invert act on the top entry.
- R5: Group 010 pops the top entry, drives it as `dmem_addr`, and pushes `dmem_rdata`.
- R6: Group 011 pops two entries and holds `dmem_we` high for that one cycle. `dmem_addr` is the top entry and `dmem_wdata` is the second entry. In every other cycle, `dmem_we` is low.
- R7: Group 100 pops two entries and pushes 1 or 0. Sub-code 000 tests second==top. Sub-code 001 tests that second−top is nonzero with sign bit clear. Sub-code 010 tests that second−top is zero or has its sign bit set.
- R8: Group 101 pops two entries: the target on top and the condition beneath it. Sub-code 000 jumps when the condition is zero. Sub-code 001 jumps when it is nonzero. If no jump is taken, the PC advances by 2.
- R9: Group 110 pushes PC+2. Group 111 pops the top entry and loads it into the PC.
- R10: The stack holds 16 entries. `stack_full` is 1 at depth 16, and a push at that depth is ignored.
- R11: An instruction that pops more entries than the stack holds leaves the stack unchanged, including its push. An absent top or second entry reads as zero.
- R12: Group 100 with sub-codes 011–111, and group 101 with sub-codes 010–111, pop two entries, push nothing and advance the PC by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data address, the top stack entry |
| dmem_wdata | output | 32 | Store data, the second stack entry |
| dmem_we | output | 1 | Store strobe for this cycle |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| stack_empty | output | 1 | Stack depth is zero |
| stack_full | output | 1 | Stack depth is at capacity |

## Verification
The bench builds constants on the stack by pushing the PC, masking it to zero and adding an immediate. Each computed value is then stored to memory, so operand order shows up directly: a core that reversed the operands of subtract or compare would store the wrong value. Compare cases sit on the equality boundary and use negative operands, which catches a greater-than that ignores the zero flag or reads the sign bit wrongly. The bench fills the stack to 17 pushes and reads back the top entry through a jump; a stack that overwrote or grew past capacity would land on the wrong address. Underflowing pops, undefined compare and branch sub-codes, and branches in both polarities are each checked through the PC and the empty flag. A core that pushed after an ignored pop, or branched on a reserved code, would show a different PC or depth.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int INSTR_W = 16;
    localparam int IMM_W   = 10;

    typedef enum logic [2:0] {
        GRP_ALU     = 3'b000,
        GRP_ALUI    = 3'b001,
        GRP_LOAD    = 3'b010,
        GRP_STORE   = 3'b011,
        GRP_CMP     = 3'b100,
        GRP_BRANCH  = 3'b101,
        GRP_SAVEPC  = 3'b110,
        GRP_JUMPTOS = 3'b111
    } grp_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_NEG = 3'b010,
        OP_MUL = 3'b011,
        OP_AND = 3'b100,
        OP_OR  = 3'b101,
        OP_XOR = 3'b110,
        OP_NOT = 3'b111
    } aop_e;

    typedef enum logic [1:0] {
        SRC_ALU  = 2'd0,
        SRC_REL  = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_LINK = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_COND = 2'd1,
        NPC_TOS  = 2'd2
    } npc_e;

    typedef struct packed {
        logic [1:0] pops;
        logic       push;
        src_e       src;
        logic       use_imm;
        logic       is_rel;
        logic       mem_we;
        npc_e       npc;
        logic       br_nz;
    } ctl_t;

endpackage

// File: rtl/stk_lifo.sv
module stk_lifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   pop_cnt,
    input  logic         push_en,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic [W-1:0] second,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [CW-1:0] cnt;
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] after_pop, cnt_m1, cnt_m2;
    logic          pop_ok, push_ok;

    // Underflowing instruction: leave the stack untouched entirely.
    assign pop_ok    = {{(CW-2){1'b0}}, pop_cnt} <= cnt;
    assign after_pop = cnt - {{(CW-2){1'b0}}, pop_cnt};
    assign push_ok   = pop_ok && push_en && (after_pop < CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (pop_ok) begin
            cnt <= after_pop + {{(CW-1){1'b0}}, push_ok};
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[after_pop[AW-1:0]] <= push_data;
        end
    end

    assign cnt_m1 = cnt - CW'(1);
    assign cnt_m2 = cnt - CW'(2);
    assign top    = (cnt >= CW'(1)) ? mem[cnt_m1[AW-1:0]] : '0;
    assign second = (cnt >= CW'(2)) ? mem[cnt_m2[AW-1:0]] : '0;
    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  aop_e         op,
    input  logic         is_rel,
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic [W-1:0] s,
    output logic [W-1:0] result,
    output logic         rel_true
);
    logic [W-1:0] add_a, add_b, sum;
    logic         cin, zero, sgn;
    logic [2:0]   code;

    // One adder serves add, subtract, negate and every relation.
    always_comb begin
        add_a = p;
        add_b = q;
        cin   = 1'b0;
        if (is_rel || op == OP_SUB) begin
            add_b = ~q;
            cin   = 1'b1;
        end else if (op == OP_NEG) begin
            add_a = '0;
            add_b = ~s;
            cin   = 1'b1;
        end
    end

    assign sum  = add_a + add_b + {{(W-1){1'b0}}, cin};
    assign zero = (sum == '0);
    assign sgn  = sum[W-1];
    assign code = op;

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG: result = sum;
            OP_MUL:                 result = p * q;
            OP_AND:                 result = p & q;
            OP_OR:                  result = p | q;
            OP_XOR:                 result = p ^ q;
            OP_NOT:                 result = ~s;
        endcase
    end

    always_comb begin
        case (code)
            3'b000:  rel_true = zero;
            3'b001:  rel_true = !sgn && !zero;
            3'b010:  rel_true = sgn || zero;
            default: rel_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output ctl_t               ctl,
    output aop_e               op,
    output logic [W-1:0]       imm_x
);
    grp_e       grp;
    logic [2:0] sub;

    assign grp   = grp_e'(instr[15:13]);
    assign sub   = instr[12:10];
    assign op    = aop_e'(sub);
    assign imm_x = {{(W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    always_comb begin
        ctl = '{pops: 2'd0, push: 1'b0, src: SRC_ALU, use_imm: 1'b0,
                is_rel: 1'b0, mem_we: 1'b0, npc: NPC_SEQ, br_nz: 1'b0};
        unique case (grp)
            GRP_ALU: begin
                ctl.pops = 2'd2;
                ctl.push = 1'b1;
            end
            GRP_ALUI: begin
                ctl.pops    = 2'd1;
                ctl.push    = 1'b1;
                ctl.use_imm = 1'b1;
            end
            GRP_LOAD: begin
                ctl.pops = 2'd1;
                ctl.push = 1'b1;
                ctl.src  = SRC_MEM;
            end
            GRP_STORE: begin
                ctl.pops   = 2'd2;
                ctl.mem_we = 1'b1;
            end
            GRP_CMP: begin
                ctl.pops   = 2'd2;
                ctl.is_rel = 1'b1;
                ctl.src    = SRC_REL;
                ctl.push   = (sub <= 3'b010);
            end
            GRP_BRANCH: begin
                ctl.pops  = 2'd2;
                ctl.br_nz = sub[0];
                ctl.npc   = (sub[2:1] == 2'b00) ? NPC_COND : NPC_SEQ;
            end
            GRP_SAVEPC: begin
                ctl.push = 1'b1;
                ctl.src  = SRC_LINK;
            end
            GRP_JUMPTOS: begin
                ctl.pops = 2'd1;
                ctl.npc  = NPC_TOS;
            end
        endcase
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    output logic [W-1:0]       imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [W-1:0]       dmem_addr,
    output logic [W-1:0]       dmem_wdata,
    output logic               dmem_we,
    input  logic [W-1:0]       dmem_rdata,
    output logic               stack_empty,
    output logic               stack_full
);
    logic [W-1:0] pc, pc_inc, pc_nxt;
    logic [W-1:0] tos, nos, imm_x, op_p, op_q, alu_res, push_val;
    logic         rel_true, take;
    ctl_t         ctl;
    aop_e         op;

    stk_decode #(.W(W)) u_dec (
        .instr (imem_data),
        .ctl   (ctl),
        .op    (op),
        .imm_x (imm_x)
    );

    assign op_p = ctl.use_imm ? tos   : nos;
    assign op_q = ctl.use_imm ? imm_x : tos;

    stk_alu #(.W(W)) u_alu (
        .op       (op),
        .is_rel   (ctl.is_rel),
        .p        (op_p),
        .q        (op_q),
        .s        (tos),
        .result   (alu_res),
        .rel_true (rel_true)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_ALU:  push_val = alu_res;
            SRC_REL:  push_val = {{(W-1){1'b0}}, rel_true};
            SRC_MEM:  push_val = dmem_rdata;
            SRC_LINK: push_val = pc_inc;
        endcase
    end

    stk_lifo #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .pop_cnt   (ctl.pops),
        .push_en   (ctl.push),
        .push_data (push_val),
        .top       (tos),
        .second    (nos),
        .empty     (stack_empty),
        .full      (stack_full)
    );

    assign pc_inc = pc + W'(2);
    assign take   = ctl.br_nz ? (nos != '0) : (nos == '0);

    always_comb begin
        unique case (ctl.npc)
            NPC_SEQ:  pc_nxt = pc_inc;
            NPC_COND: pc_nxt = take ? tos : pc_inc;
            NPC_TOS:  pc_nxt = tos;
            default:  pc_nxt = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_nxt;
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = tos;
    assign dmem_wdata = nos;
    assign dmem_we    = ctl.mem_we;

endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pc,
    input logic [15:0]  instr,
    input logic         we,
    input logic         empty,
    input logic         full,
    input logic [W-1:0] tos
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (pc == '0 && empty && !full));

    // R2
    a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (instr[15:13] != 3'b101 && instr[15:13] != 3'b111)
        |=> pc == $past(pc) + W'(2));

    // R6
    a_r6_store_strobe: assert property (@(posedge clk) disable iff (rst)
        we == (instr[15:13] == 3'b011));

    // R9
    a_r9_jump_tos: assert property (@(posedge clk) disable iff (rst)
        (instr[15:13] == 3'b111) |=> pc == $past(tos));

    // R9
    a_r9_link_push: assert property (@(posedge clk) disable iff (rst)
        (instr[15:13] == 3'b110 && !full) |=> tos == $past(pc) + W'(2));

    // R10
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R10
    a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && instr[15:13] == 3'b110) |=> full);

endmodule

bind stk_core stk_core_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc    (imem_addr),
    .instr (imem_data),
    .we    (dmem_we),
    .empty (stack_empty),
    .full  (stack_full),
    .tos   (tos)
);

// File: tb/tb_stk_core.sv
`timescale 1ns/100ps
module tb_stk_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [15:0] imem_data;
    logic        dmem_we, stack_empty, stack_full;

    logic [15:0] imem [256];
    logic [31:0] dmem [64];
    logic        tb_wr = 1'b0;
    logic [5:0]  tb_waddr = '0;
    logic [31:0] tb_wdata = '0;

    int checks = 0;
    int fails  = 0;
    int wp     = 0;
    int cyc    = 0;

    localparam logic [31:0] SENT = 32'hA5A5_5A5A;

    always #2.5 clk = ~clk;

    stk_core dut (
        .clk         (clk),
        .rst         (rst),
        .imem_addr   (imem_addr),
        .imem_data   (imem_data),
        .dmem_addr   (dmem_addr),
        .dmem_wdata  (dmem_wdata),
        .dmem_we     (dmem_we),
        .dmem_rdata  (dmem_rdata),
        .stack_empty (stack_empty),
        .stack_full  (stack_full)
    );

    assign imem_data  = imem[imem_addr[8:1]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (tb_wr) dmem[tb_waddr] <= tb_wdata;
        else if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic [2:0]  g;
        logic [2:0]  s;
        logic [9:0]  a;
        logic [9:0]  b;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VT [NV] = '{
        '{3'd0, 3'd0, 10'd7,    10'd5,    32'd12},
        '{3'd0, 3'd1, 10'd7,    10'd5,    32'd2},
        '{3'd0, 3'd1, 10'd3,    10'd10,   32'hFFFF_FFF9},
        '{3'd0, 3'd2, 10'd3,    10'd9,    32'hFFFF_FFF7},
        '{3'd0, 3'd3, 10'h3FA,  10'd7,    32'hFFFF_FFD6},
        '{3'd0, 3'd4, 10'd12,   10'd10,   32'd8},
        '{3'd0, 3'd5, 10'd12,   10'd10,   32'd14},
        '{3'd0, 3'd6, 10'd12,   10'd10,   32'd6},
        '{3'd0, 3'd7, 10'd1,    10'd0,    32'hFFFF_FFFF},
        '{3'd1, 3'd0, 10'd100,  10'h3FF,  32'd99},
        '{3'd1, 3'd1, 10'd5,    10'h3FD,  32'd8},
        '{3'd1, 3'd2, 10'h3FC,  10'd0,    32'd4},
        '{3'd1, 3'd3, 10'd20,   10'h3EC,  32'hFFFF_FE70},
        '{3'd1, 3'd4, 10'h3FF,  10'h0F0,  32'h0000_00F0},
        '{3'd1, 3'd5, 10'd1,    10'h300,  32'hFFFF_FF01},
        '{3'd1, 3'd6, 10'h3FF,  10'd1,    32'hFFFF_FFFE},
        '{3'd1, 3'd7, 10'd0,    10'd5,    32'hFFFF_FFFF},
        '{3'd4, 3'd0, 10'd5,    10'd5,    32'd1},
        '{3'd4, 3'd0, 10'd5,    10'd6,    32'd0},
        '{3'd4, 3'd1, 10'd6,    10'd5,    32'd1},
        '{3'd4, 3'd1, 10'd5,    10'd5,    32'd0},
        '{3'd4, 3'd1, 10'h3FD,  10'd2,    32'd0},
        '{3'd4, 3'd2, 10'd5,    10'd5,    32'd1},
        '{3'd4, 3'd2, 10'h3FD,  10'd2,    32'd1},
        '{3'd4, 3'd2, 10'd4,    10'd2,    32'd0}
    };

    function automatic logic [15:0] enc(input logic [2:0] g, input logic [2:0] s,
                                        input logic [9:0] i);
        return {g, s, i};
    endfunction

    task automatic emit(input logic [15:0] w);
        imem[wp] = w;
        wp = wp + 1;
    endtask

    // Constant k: push PC+2, mask to zero, add sign-extended k.
    task automatic put_lit(input logic [9:0] k);
        emit(enc(3'b110, 3'b000, 10'd0));
        emit(enc(3'b001, 3'b100, 10'd0));
        emit(enc(3'b001, 3'b000, k));
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
        wp = 0;
    endtask

    task automatic poke(input logic [5:0] a, input logic [31:0] d);
        rst = 1'b1;
        tb_wr = 1'b1; tb_waddr = a; tb_wdata = d;
        @(posedge clk); @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic apply_reset();
        poke(6'd16, SENT);
        poke(6'd17, SENT);
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        clear_prog();
        apply_reset();

        // R1 reset state
        check("R1 pc", imem_addr, 32'd0);
        check("R1 empty", {31'd0, stack_empty}, 32'd1);
        check("R1 full", {31'd0, stack_full}, 32'd0);

        // Table of operations: R3, R4, R7
        for (int k = 0; k < NV; k++) begin
            clear_prog();
            put_lit(VT[k].a);
            if (VT[k].g == 3'b001) begin
                emit(enc(3'b001, VT[k].s, VT[k].b));
            end else begin
                put_lit(VT[k].b);
                emit(enc(VT[k].g, VT[k].s, 10'd0));
            end
            put_lit(10'h040);
            emit(enc(3'b011, 3'b000, 10'd0));
            apply_reset();
            run(wp);
            check(VT[k].g == 3'b000 ? "R3 alu" : (VT[k].g == 3'b001 ? "R4 imm" : "R7 cmp"),
                  dmem[16], VT[k].e);
        end

        // R2 sequential advance
        clear_prog(); put_lit(10'd1); put_lit(10'd2);
        apply_reset(); run(6);
        check("R2 pc step", imem_addr, 32'd12);

        // R5 load
        clear_prog(); put_lit(10'd20); emit(enc(3'b010, 3'b000, 10'd0));
        put_lit(10'h040); emit(enc(3'b011, 3'b000, 10'd0));
        poke(6'd5, 32'hDEAD_BEEF);
        apply_reset(); run(wp);
        check("R5 load", dmem[16], 32'hDEAD_BEEF);

        // R6 store port timing
        clear_prog(); put_lit(10'd77); put_lit(10'h044); emit(enc(3'b011, 3'b000, 10'd0));
        apply_reset(); run(6);
        check("R6 we", {31'd0, dmem_we}, 32'd1);
        check("R6 addr", dmem_addr, 32'h44);
        check("R6 wdata", dmem_wdata, 32'd77);
        run(1);
        check("R6 we low", {31'd0, dmem_we}, 32'd0);
        check("R6 mem", dmem[17], 32'd77);

        // R8 branch on zero, taken and not taken; branch on nonzero
        clear_prog(); put_lit(10'd0); put_lit(10'h080); emit(enc(3'b101, 3'b000, 10'd0));
        apply_reset(); run(7);
        check("R8 bz taken", imem_addr, 32'h80);
        check("R8 pops", {31'd0, stack_empty}, 32'd1);
        clear_prog(); put_lit(10'd3); put_lit(10'h080); emit(enc(3'b101, 3'b000, 10'd0));
        apply_reset(); run(7);
        check("R8 bz not taken", imem_addr, 32'd14);
        clear_prog(); put_lit(10'd3); put_lit(10'h080); emit(enc(3'b101, 3'b001, 10'd0));
        apply_reset(); run(7);
        check("R8 bnz taken", imem_addr, 32'h80);

        // R9 link push and jump from stack
        clear_prog(); emit(enc(3'b110, 3'b000, 10'd0));
        put_lit(10'h040); emit(enc(3'b011, 3'b000, 10'd0));
        apply_reset(); run(5);
        check("R9 link", dmem[16], 32'd2);
        clear_prog(); put_lit(10'h060); emit(enc(3'b111, 3'b000, 10'd0));
        apply_reset(); run(4);
        check("R9 jump", imem_addr, 32'h60);

        // R10 capacity: 17 pushes, the last ignored; top read through a jump
        clear_prog();
        for (int i = 0; i < 17; i++) emit(enc(3'b110, 3'b000, 10'd0));
        emit(enc(3'b111, 3'b000, 10'd0));
        apply_reset(); run(16);
        check("R10 full", {31'd0, stack_full}, 32'd1);
        run(1);
        check("R10 still full", {31'd0, stack_full}, 32'd1);
        run(1);
        check("R10 push ignored", imem_addr, 32'd32);

        // R11 underflow leaves stack unchanged; absent top reads zero
        clear_prog(); put_lit(10'd9); emit(enc(3'b000, 3'b000, 10'd0));
        emit(enc(3'b111, 3'b000, 10'd0));
        apply_reset(); run(5);
        check("R11 underflow", imem_addr, 32'd9);
        check("R11 empty", {31'd0, stack_empty}, 32'd1);
        clear_prog(); emit(enc(3'b110, 3'b000, 10'd0)); emit(enc(3'b111, 3'b000, 10'd0));
        imem[1] = enc(3'b111, 3'b000, 10'd0);
        imem[0] = enc(3'b111, 3'b000, 10'd0);
        apply_reset(); run(1);
        check("R11 zero top", imem_addr, 32'd0);

        // R12 reserved sub-codes
        clear_prog(); put_lit(10'd1); put_lit(10'd2); emit(enc(3'b100, 3'b011, 10'd0));
        apply_reset(); run(7);
        check("R12 cmp pc", imem_addr, 32'd14);
        check("R12 cmp empty", {31'd0, stack_empty}, 32'd1);
        clear_prog(); put_lit(10'd0); put_lit(10'h080); emit(enc(3'b101, 3'b010, 10'd0));
        apply_reset(); run(7);
        check("R12 br pc", imem_addr, 32'd14);
        check("R12 br empty", {31'd0, stack_empty}, 32'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule